// File: doc/BRIEF.md
# 8-bit Processor Memory Bus Cycle Sequencer

This block turns bus requests from a small 8-bit processor core into the pin-level timing of an external memory bus. The core asks for one of three cycle kinds (opcode fetch, memory read or memory write) and supplies an address and, for writes, a data byte. The sequencer then steps through a fixed series of clock states. It places the address on the bus at the start of the cycle. It drives the active-low memory-request, read, write, fetch-cycle and refresh strobes, each on its own half-clock boundary, and it raises a one-clock done pulse when the cycle ends. Read data and fetched opcodes come back on a separate output.

Ordinary reads and writes take three clock periods. An opcode fetch takes four: a shortened read of the opcode, then a refresh phase. During that phase the refresh strobe is active and a 7-bit refresh counter appears on the low address lines, so that dynamic memory can be refreshed without separate logic. A wait input stretches any cycle by whole clock periods. The next request may be presented during the final state of the current cycle, which lets cycles run back to back with no idle clock between them.

Top module: `bus_cycle_seq`

## Requirements
- R1: With no wait states, a read or write cycle lasts exactly three clock periods (T1, T2, T3). The done output is high for the whole of the last state of every cycle and is low at all other times.
- R2: The cycle address is on bus_addr from the rising edge that starts T1. mreq_n goes low on the falling edge inside T1, half a clock later. For reads and writes, mreq_n stays low until the falling edge inside T3.
- R3: In a read cycle (kind 2'b01, or kind 2'b11, which is handled as a read), rd_n is low from the falling edge of T1 to the falling edge of T3. rdata takes the bus_din value present at the falling edge of T3.
- R4: In a write cycle (kind 2'b10), wr_n is low from the falling edge of T2 to the falling edge of T3. rd_n never goes low. bus_dout carries the write byte and bus_dout_en is high from T1 to the end of T3.
- R5: An opcode fetch (kind 2'b00) lasts four clock periods with no waits. m1_n is low from the start of T1 to the start of T3. rd_n and mreq_n are low from the falling edge of T1 to the rising edge of T3. The opcode is taken from bus_din at the rising edge that starts T3, and later changes of bus_din do not alter rdata.
- R6: During T3 and T4 of a fetch, rfsh_n is low. mreq_n is low from the falling edge of T3 to the falling edge of T4. bus_addr then reads {8'h00, bit 7 of the fetch address, refresh count}, the count being in bits 6:0.
- R7: The refresh count is 7 bits wide, starts at 0 after reset, and advances by one at the end of each fetch. It wraps from 127 to 0.
- R8: wait_n is sampled only on the falling edge inside T2 and inside each wait state. Each low sample adds one wait state of one clock period before T3. wait_n has no effect at any other time.
- R9: memrd_n is low exactly when mreq_n and rd_n are both low.
- R10: A request (req_valid high) is accepted only at a rising edge that ends an idle clock or the last state of a cycle. After a last state, the accepted cycle starts T1 with no gap. A request held during any other state is ignored.
- R11: After reset, the sequencer is idle with all strobes high, done low, bus_dout_en low, bus_addr 0 and rdata 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; states begin on rising edges |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core presents a cycle request |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | High during the last state of a cycle |
| rdata | output | 8 | Byte read or opcode fetched |
| bus_addr | output | 16 | Address bus |
| bus_dout | output | 8 | Write data toward memory |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | 8 | Data from memory |
| wait_n | input | 1 | Active-low wait request |
| mreq_n | output | 1 | Memory request strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| m1_n | output | 1 | Opcode fetch cycle marker |
| rfsh_n | output | 1 | Refresh phase strobe |
| memrd_n | output | 1 | Combined memory read qualifier |

## Verification
The bench builds the block with its defaults: a 16-bit address, an 8-bit data path and a 7-bit refresh count. The 7-bit count lets a chain of 130 back-to-back fetches carry the count through its wrap from 127 to 0, and the 8 upper zero bits plus the kept bit 7 make the refresh address fully visible. Strobes are checked in both halves of every state. This exposes each half-clock edge, the wait stretching of up to three states, and requests held in the middle of a cycle.

// File: rtl/bus_seq_pkg.sv
// Shared types of the bus cycle sequencer: state and request kind encodings.
// Assumes one bus cycle is active at a time.
package bus_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4,
        ST_T4   = 3'd5
    } bus_state_e;

    typedef enum logic [1:0] {
        K_FETCH    = 2'b00,
        K_READ     = 2'b01,
        K_WRITE    = 2'b10,
        K_READ_ALT = 2'b11
    } bus_kind_e;

endpackage

// File: rtl/bus_seq_fsm.sv
// State sequencer. It advances one state per rising edge. It keeps a copy of
// the state taken on the falling edge, so that a strobe decoder can tell the
// two halves of a state apart. It samples wait_n on the falling edge of T2
// and of each wait state.
// Assumes is_fetch reflects the kind of the cycle in progress.
module bus_seq_fsm
    import bus_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       is_fetch,
    input  logic       wait_n,
    output bus_state_e state,
    output bus_state_e st_f,
    output logic       wait_s,
    output logic       accept,
    output logic       last
);

    bus_state_e state_nx;

    assign last   = ((state == ST_T3) && !is_fetch) || (state == ST_T4);
    assign accept = req_valid && ((state == ST_IDLE) || last);

    // Next-state selection, with acceptance allowed from idle or the last state.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = ST_IDLE;
            ST_T1:   state_nx = ST_T2;
            ST_T2:   state_nx = wait_s ? ST_TW : ST_T3;
            ST_TW:   state_nx = wait_s ? ST_TW : ST_T3;
            ST_T3:   state_nx = is_fetch ? ST_T4 : ST_IDLE;
            ST_T4:   state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
        if (accept) begin
            state_nx = ST_T1;
        end
    end

    // Rising-edge state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Falling-edge state copy and wait sample.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            st_f   <= ST_IDLE;
            wait_s <= 1'b0;
        end else begin
            st_f   <= state;
            wait_s <= ((state == ST_T2) || (state == ST_TW)) && !wait_n;
        end
    end

endmodule

// File: rtl/bus_seq_refresh.sv
// Refresh counter. It advances once at the end of each fetch, in the last
// refresh state, and wraps at its width.
// Assumes ST_T4 occurs only in fetch cycles.
module bus_seq_refresh
    import bus_seq_pkg::*;
#(
    parameter int RW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_state_e    state,
    output logic [RW-1:0] rcnt
);

    // Count one step per completed fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcnt <= '0;
        end else if (state == ST_T4) begin
            rcnt <= rcnt + 1'b1;
        end
    end

endmodule

// File: rtl/bus_seq_strobes.sv
// Strobe decoder. It builds the active-low bus strobes from the current state
// and from which half of that state is running (second half when the
// falling-edge copy equals the state).
// Assumes the state changes only on rising edges; only the wait state repeats.
module bus_seq_strobes
    import bus_seq_pkg::*;
(
    input  bus_state_e state,
    input  bus_state_e st_f,
    input  logic       is_fetch,
    input  logic       is_read,
    input  logic       is_write,
    output logic       mreq_n,
    output logic       rd_n,
    output logic       wr_n,
    output logic       m1_n,
    output logic       rfsh_n,
    output logic       memrd_n
);

    logic h2;
    logic in_t1, in_t2, in_tw, in_t3, in_t4;
    logic mreq, rd, wr;

    assign h2    = (st_f == state);
    assign in_t1 = (state == ST_T1);
    assign in_t2 = (state == ST_T2);
    assign in_tw = (state == ST_TW);
    assign in_t3 = (state == ST_T3);
    assign in_t4 = (state == ST_T4);

    // Active-high strobe terms per state and half.
    always_comb begin
        mreq = (in_t1 && h2) || in_t2 || in_tw
             || (in_t3 && !h2 && !is_fetch)
             || (in_t3 && h2 && is_fetch)
             || (in_t4 && !h2);
        rd   = !is_write && ((in_t1 && h2) || in_t2 || in_tw
             || (in_t3 && !h2 && is_read));
        wr   = is_write && ((in_t2 && h2) || in_tw || (in_t3 && !h2));
    end

    assign mreq_n  = !mreq;
    assign rd_n    = !rd;
    assign wr_n    = !wr;
    assign m1_n    = !(is_fetch && (in_t1 || in_t2 || in_tw));
    assign rfsh_n  = !(is_fetch && (in_t3 || in_t4));
    assign memrd_n = mreq_n | rd_n;

endmodule

// File: rtl/bus_seq_datapath.sv
// Datapath. It holds the accepted request, drives the address and write
// data, and returns read data. An opcode is captured on the rising edge
// into T3; read data on the falling edge inside T3. During refresh, the
// address carries zeros, the kept bit of the fetch address and the count.
// Assumes accept is high only where a new cycle may start.
module bus_seq_datapath
    import bus_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int RW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  bus_state_e    state,
    input  logic          wait_s,
    input  logic [DW-1:0] bus_din,
    input  logic [RW-1:0] rcnt,
    output logic          is_fetch,
    output logic          is_read,
    output logic          is_write,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_en,
    output logic [DW-1:0] rdata
);

    localparam int HI_W = AW - RW - 1;

    bus_kind_e     kind_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] op_q;
    logic [DW-1:0] rd_q;
    logic          rfsh_ph;

    assign is_fetch = (kind_q == K_FETCH);
    assign is_write = (kind_q == K_WRITE);
    assign is_read  = (kind_q == K_READ) || (kind_q == K_READ_ALT);
    assign rfsh_ph  = is_fetch && ((state == ST_T3) || (state == ST_T4));

    // Capture the request when a cycle is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= K_READ;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            kind_q  <= bus_kind_e'(req_kind);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Opcode capture on the rising edge that leaves the fetch part.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0;
        end else if (is_fetch && ((state == ST_T2) || (state == ST_TW)) && !wait_s) begin
            op_q <= bus_din;
        end
    end

    // Read data capture on the falling edge inside T3.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (is_read && (state == ST_T3)) begin
            rd_q <= bus_din;
        end
    end

    // Address and data drive.
    always_comb begin
        bus_addr    = addr_q;
        if (rfsh_ph) begin
            bus_addr = {{HI_W{1'b0}}, addr_q[RW], rcnt};
        end
        bus_dout    = wdata_q;
        bus_dout_en = is_write && (state != ST_IDLE) && (state != ST_T4);
        rdata       = is_fetch ? op_q : rd_q;
    end

endmodule

// File: rtl/bus_cycle_seq.sv
// Top of the bus cycle sequencer. It joins the state sequencer, the strobe
// decoder, the refresh counter and the datapath.
// Assumes one clock domain; strobes change on both edges of clk.
module bus_cycle_seq
    import bus_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int RW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_en,
    input  logic [DW-1:0] bus_din,
    input  logic          wait_n,
    output logic          mreq_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          m1_n,
    output logic          rfsh_n,
    output logic          memrd_n
);

    bus_state_e    state;
    bus_state_e    st_f;
    logic          wait_s;
    logic          accept;
    logic          last;
    logic          is_fetch;
    logic          is_read;
    logic          is_write;
    logic [RW-1:0] rcnt;

    assign done = last;

    bus_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .is_fetch  (is_fetch),
        .wait_n    (wait_n),
        .state     (state),
        .st_f      (st_f),
        .wait_s    (wait_s),
        .accept    (accept),
        .last      (last)
    );

    bus_seq_refresh #(.RW(RW)) u_rfsh (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .rcnt  (rcnt)
    );

    bus_seq_strobes u_strb (
        .state    (state),
        .st_f     (st_f),
        .is_fetch (is_fetch),
        .is_read  (is_read),
        .is_write (is_write),
        .mreq_n   (mreq_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .m1_n     (m1_n),
        .rfsh_n   (rfsh_n),
        .memrd_n  (memrd_n)
    );

    bus_seq_datapath #(.AW(AW), .DW(DW), .RW(RW)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_kind    (req_kind),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .state       (state),
        .wait_s      (wait_s),
        .bus_din     (bus_din),
        .rcnt        (rcnt),
        .is_fetch    (is_fetch),
        .is_read     (is_read),
        .is_write    (is_write),
        .bus_addr    (bus_addr),
        .bus_dout    (bus_dout),
        .bus_dout_en (bus_dout_en),
        .rdata       (rdata)
    );

endmodule

// File: rtl/bus_cycle_seq_chk.sv
// Checker for the bus cycle sequencer, bound to the top module. It watches
// strobes, state, the wait sample and the refresh count on rising edges.
// Assumes the synchronous active-low reset of the top.
module bus_cycle_seq_chk
    import bus_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int RW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input bus_state_e    state,
    input logic          wait_s,
    input logic [RW-1:0] rcnt,
    input logic          done,
    input logic          wr_n,
    input logic          rd_n,
    input logic          m1_n,
    input logic          rfsh_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_dout_en
);

    // R4: read and write strobes are never low together.
    assert_rw_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n && !rd_n));

    // R4: a low write strobe always has write data driven.
    assert_wr_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> bus_dout_en);

    // R6: the refresh phase never overlaps the fetch marker.
    assert_rfsh_m1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rfsh_n && !m1_n));

    // R6: the upper address bits are zero during refresh.
    assert_rfsh_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rfsh_n |-> (bus_addr[AW-1:RW+1] == '0));

    // R7: the count advances by one after each refresh state.
    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T4) |=> (rcnt == $past(rcnt) + 1'b1));

    // R8: a low wait sample holds the sequencer in a wait state.
    assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (((state == ST_T2) || (state == ST_TW)) && wait_s) |=> (state == ST_TW));

    // R10: a cycle starts only after idle or a last state.
    assert_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T1) |-> ($past(state) == ST_IDLE || $past(done)));

    // R1: after a done state the sequencer idles, restarts, or finishes refresh.
    assert_done_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ((state == ST_IDLE) || (state == ST_T1) || (state == ST_T4)));

endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(.AW(AW), .RW(RW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .wait_s      (wait_s),
    .rcnt        (rcnt),
    .done        (done),
    .wr_n        (wr_n),
    .rd_n        (rd_n),
    .m1_n        (m1_n),
    .rfsh_n      (rfsh_n),
    .bus_addr    (bus_addr),
    .bus_dout_en (bus_dout_en)
);

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;

    localparam int N = 437;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b01;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        done;
    logic [7:0]  rdata;
    logic [15:0] bus_addr;
    logic [7:0]  bus_dout;
    logic        bus_dout_en;
    logic [7:0]  bus_din = '0;
    logic        wait_n = 1'b1;
    logic        mreq_n, rd_n, wr_n, m1_n, rfsh_n, memrd_n;

    int n_tests = 0;
    int n_fail = 0;

    logic [1:0]  t_kind [N];
    logic [15:0] t_addr [N];
    logic [7:0]  t_data [N];
    logic [7:0]  t_din  [N];
    int          t_wait [N];
    bit          t_poke [N];
    bit          t_chain[N];
    int          t_gap  [N];

    logic [6:0]  rc_exp = '0;

    always #5 clk = ~clk;

    bus_cycle_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .bus_din(bus_din), .wait_n(wait_n), .mreq_n(mreq_n), .rd_n(rd_n),
        .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n), .memrd_n(memrd_n)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, expv, $time);
        end
    endtask

    // Expected active-low strobes {mreq,rd,wr,m1,rfsh,memrd}; st 1=T1 2=T2 3=TW 4=T3 5=T4.
    function automatic logic [5:0] exp_strobes(input logic [1:0] k, input int st, input bit h);
        bit f = (k == 2'b00);
        bit w = (k == 2'b10);
        bit r = !f && !w;
        bit mq, rd, wr, m1, rf;
        mq = (st == 1 && h) || st == 2 || st == 3 || (st == 4 && !h && !f)
           || (f && st == 4 && h) || (f && st == 5 && !h);
        rd = !w && ((st == 1 && h) || st == 2 || st == 3 || (r && st == 4 && !h));
        wr = w && ((st == 2 && h) || st == 3 || (st == 4 && !h));
        m1 = f && st <= 3;
        rf = f && st >= 4;
        return ~{mq, rd, wr, m1, rf, mq && rd};
    endfunction

    task automatic check_idle(input string rq);
        chk({mreq_n, rd_n, wr_n, m1_n, rfsh_n, memrd_n} == 6'h3f, rq, "idle strobes",
            {mreq_n, rd_n, wr_n, m1_n, rfsh_n, memrd_n}, 6'h3f);
        chk(done == 1'b0, rq, "idle done", done, 0);
        chk(bus_dout_en == 1'b0, rq, "idle dout_en", bus_dout_en, 0);
    endtask

    task automatic check_half(input int i, input int st, input bit h, input bit last);
        logic [5:0]  es = exp_strobes(t_kind[i], st, h);
        bit          f = (t_kind[i] == 2'b00);
        bit          w = (t_kind[i] == 2'b10);
        logic [15:0] ea = (f && st >= 4) ? {8'h00, t_addr[i][7], rc_exp} : t_addr[i];
        chk({mreq_n, rd_n, wr_n, m1_n, rfsh_n, memrd_n} == es, "R2 R3 R4 R5 R6 R9",
            $sformatf("strobes st%0d h%0d", st, h),
            {mreq_n, rd_n, wr_n, m1_n, rfsh_n, memrd_n}, es);
        chk(bus_addr == ea, (f && st >= 4) ? "R6 R7" : "R2 R10", "address", bus_addr, ea);
        chk(done == last, "R1", "done", done, last);
        chk(bus_dout_en == (w && st <= 4), "R4", "dout_en", bus_dout_en, w && st <= 4);
        if (w) chk(bus_dout == t_data[i], "R4", "dout", bus_dout, t_data[i]);
    endtask

    task automatic present(input int i);
        req_valid = 1'b1;
        req_kind  = t_kind[i];
        req_addr  = t_addr[i];
        req_wdata = t_data[i];
    endtask

    task automatic run_txn(input int i);
        int rem = t_wait[i];
        int st = 1;
        bit fin = 0;
        bit f = (t_kind[i] == 2'b00);
        bit last;
        while (!fin) begin
            @(posedge clk); #2;
            last = (st == 4 && !f) || st == 5;
            if (st == 1) begin
                req_valid = 1'b0;
                bus_din = t_din[i];
                wait_n = $urandom_range(1);   // R8: ignored outside T2 and TW
            end
            if (st == 2 || st == 3) wait_n = (rem == 0);
            if (st == 2 && t_poke[i]) begin   // R10: request during a busy state
                req_valid = 1'b1;
                req_kind = 2'($urandom);
                req_addr = 16'($urandom);
                req_wdata = 8'($urandom);
            end
            if (st == 4) wait_n = $urandom_range(1);
            if (st == 4 && f) bus_din = ~t_din[i];   // R5: after opcode capture
            if (last) begin
                if (t_chain[i] && i + 1 < N) present(i + 1);
                else req_valid = 1'b0;
            end
            check_half(i, st, 1'b0, last);
            #5;
            check_half(i, st, 1'b1, last);
            if (last && t_kind[i] != 2'b10)
                chk(rdata == t_din[i], f ? "R5" : "R3", "rdata", rdata, t_din[i]);
            case (st)
                1: st = 2;
                2, 3: begin
                    if (rem > 0) begin rem--; st = 3; end
                    else st = 4;
                end
                4: if (f) st = 5; else fin = 1;
                default: fin = 1;
            endcase
        end
        if (f) rc_exp = rc_exp + 7'd1;
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // Directed cases
        t_kind[0] = 2'b00; t_addr[0] = 16'h1280; t_data[0] = 8'h00; t_din[0] = 8'hA5; t_wait[0] = 0; t_poke[0] = 0; t_chain[0] = 0; t_gap[0] = 2;
        t_kind[1] = 2'b01; t_addr[1] = 16'h4321; t_data[1] = 8'h00; t_din[1] = 8'h3C; t_wait[1] = 0; t_poke[1] = 0; t_chain[1] = 0; t_gap[1] = 1;
        t_kind[2] = 2'b10; t_addr[2] = 16'hBEEF; t_data[2] = 8'h5A; t_din[2] = 8'h77; t_wait[2] = 0; t_poke[2] = 0; t_chain[2] = 0; t_gap[2] = 2;
        t_kind[3] = 2'b01; t_addr[3] = 16'h0F0F; t_data[3] = 8'h00; t_din[3] = 8'hC3; t_wait[3] = 2; t_poke[3] = 1; t_chain[3] = 1; t_gap[3] = 1;
        t_kind[4] = 2'b10; t_addr[4] = 16'hF00D; t_data[4] = 8'h96; t_din[4] = 8'h11; t_wait[4] = 3; t_poke[4] = 1; t_chain[4] = 1; t_gap[4] = 1;
        t_kind[5] = 2'b00; t_addr[5] = 16'h007F; t_data[5] = 8'h00; t_din[5] = 8'h69; t_wait[5] = 2; t_poke[5] = 1; t_chain[5] = 1; t_gap[5] = 1;
        t_kind[6] = 2'b11; t_addr[6] = 16'hA55A; t_data[6] = 8'h00; t_din[6] = 8'hE1; t_wait[6] = 1; t_poke[6] = 0; t_chain[6] = 0; t_gap[6] = 3;
        // R7: long chain of fetches carries the count through its wrap
        for (int i = 7; i < 137; i++) begin
            t_kind[i] = 2'b00; t_addr[i] = 16'($urandom); t_data[i] = 8'($urandom);
            t_din[i] = 8'($urandom); t_wait[i] = 0; t_poke[i] = 0; t_chain[i] = 1; t_gap[i] = 1;
        end
        // Random mix
        for (int i = 137; i < N; i++) begin
            t_kind[i] = 2'($urandom); t_addr[i] = 16'($urandom); t_data[i] = 8'($urandom);
            t_din[i] = 8'($urandom);
            t_wait[i] = ($urandom_range(1) == 0) ? 0 : int'($urandom_range(3));
            t_poke[i] = 1'($urandom); t_chain[i] = 1'($urandom);
            t_gap[i] = int'($urandom_range(3, 1));
        end

        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #5;
        // R11: reset state
        check_idle("R11");
        chk(bus_addr == 16'h0000, "R11", "reset address", bus_addr, 0);
        chk(rdata == 8'h00, "R11", "reset rdata", rdata, 0);

        @(posedge clk); #2;
        check_idle("R11");
        present(0);
        for (int i = 0; i < N; i++) begin
            run_txn(i);
            if (!(t_chain[i] && i + 1 < N)) begin
                for (int g = 0; g < t_gap[i]; g++) begin
                    @(posedge clk); #2;
                    wait_n = $urandom_range(1);   // R8: ignored while idle
                    check_idle("R10");
                    if (g == t_gap[i] - 1 && i + 1 < N) present(i + 1);
                    #5;
                    check_idle("R10");
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule